// File: doc/BRIEF.md
# Phase-Accumulator PWM Generator

This block produces one pulse-width-modulated output from a single 32-bit control register. Each clock, while running, a frequency increment is added to a phase accumulator, so the output frequency is the clock frequency times the increment over 2^ACC_W (65536 by default). The accumulator's top THR_W bits are compared with an on-time threshold, which gives a duty cycle of threshold/256 at the default widths.

Software writes new increment and threshold values into a shadow copy. If the same write carries an update request, the shadow is moved into the active copy at the next period boundary. A boundary is the carry out of the accumulator addition. While the block is stopped, or while the active increment is zero and no boundary can ever come, a pending request is applied on the next clock. To start, software writes the settings with the update request and then sets the enable bit, or sets both in one write.

Top module: `pwm_acc_gen`

## Requirements
- R1: After reset the control register reads 0x0000_0000 and the output is low.
- R2: The register at address 0 reads back as: bit 31 enable, bit 30 update-pending, bits 23:8 the written increment, bits 7:0 the written threshold. Bits 29:24 always read 0.
- R3: A write to any nonzero address changes nothing, and a read from a nonzero address returns 0.
- R4: While enable is 1, the accumulator grows by the active increment each clock, modulo 2^16. While enable is 0, the accumulator holds its value and the output is low.
- R5: While enabled, the output is high exactly when the accumulator's upper 8 bits are strictly below the active threshold. A threshold of 0 keeps the output low.
- R6: A write with bit 30 set stores new settings that reach the active copy only on a clock edge where the accumulator carries out. Until then, the old active settings drive the output.
- R7: Bit 30 reads 1 from the write that requested an update until the edge that applies it, and then reads 0. A write with bit 30 clear does not cancel a pending request and never moves settings into the active copy.
- R8: When enable is 0 or the active increment is 0, a pending update is applied on the next clock edge.
- R9: An update requested by a write that lands on a carry edge is not applied on that edge. It waits for the following carry.
- R10: Increments above 0x8000 still run, with a carry on most clocks. With increment 0xC000 and threshold 0x80, every run of 4 consecutive clocks has exactly 2 high.
- R11: With OUT_MODE set to the retimed variant, the output equals the direct output delayed by one clock, and it is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address; only 0 is decoded |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| pwm_o | output | 1 | PWM output |

## Verification
The bench builds two instances with ACC_W=16, THR_W=8 and ADDR_W=4, one with the direct output and one with the retimed output, and drives both with the same stimulus. It compares each against a behavioural model on every clock. Because the increments used (0x1000, 0x8000, 0xC000) are large, carries come within a few clocks. This makes staged updates, carry-coincident writes and the coarse-duty regime reachable in short runs. A mid-run reset gives a known accumulator phase for the carry-edge cases.

// File: rtl/pwm_acc_pkg.sv
package pwm_acc_pkg;
   localparam int CTRL_W  = 32;
   localparam int EN_POS  = 31;
   localparam int UPD_POS = 30;

   typedef enum logic {
      OUT_DIRECT  = 1'b0,
      OUT_RETIMED = 1'b1
   } out_mode_e;

   // Lowest bit of the increment field: it sits right above the threshold.
   function automatic int inc_lsb(input int thr_w);
      return thr_w;
   endfunction
endpackage

// File: rtl/pwm_acc_regs.sv
module pwm_acc_regs
   import pwm_acc_pkg::*;
#(
   parameter int ACC_W  = 16,
   parameter int THR_W  = 8,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [CTRL_W-1:0] wdata_i,
   output logic [CTRL_W-1:0] rdata_o,
   input  logic              wrap_i,
   input  logic              act_zero_i,
   output logic              en_o,
   output logic              pend_o,
   output logic [ACC_W-1:0]  sh_inc_o,
   output logic [THR_W-1:0]  sh_thr_o,
   output logic              apply_o
);
   localparam int INC_LO = inc_lsb(THR_W);
   localparam int INC_HI = INC_LO + ACC_W - 1;

   logic             sel, wr, upd_wr;
   logic             en_q, pend_q;
   logic [ACC_W-1:0] sh_inc_q;
   logic [THR_W-1:0] sh_thr_q;
   logic [CTRL_W-1:0] rd;

   assign sel    = (addr_i == '0);
   assign wr     = we_i & sel;
   assign upd_wr = wr & wdata_i[UPD_POS];

   // A request is applied on a boundary, or at once when no boundary can come.
   assign apply_o = pend_q & (~en_q | wrap_i | act_zero_i);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q     <= 1'b0;
         pend_q   <= 1'b0;
         sh_inc_q <= '0;
         sh_thr_q <= '0;
      end else begin
         if (wr) begin
            en_q     <= wdata_i[EN_POS];
            sh_inc_q <= wdata_i[INC_HI:INC_LO];
            sh_thr_q <= wdata_i[THR_W-1:0];
         end
         if (upd_wr)       pend_q <= 1'b1;
         else if (apply_o) pend_q <= 1'b0;
      end
   end

   always_comb begin
      rd                 = '0;
      rd[EN_POS]         = en_q;
      rd[UPD_POS]        = pend_q;
      rd[INC_HI:INC_LO]  = sh_inc_q;
      rd[THR_W-1:0]      = sh_thr_q;
      rdata_o            = sel ? rd : '0;
   end

   generate
      if (INC_HI + 1 < UPD_POS) begin : g_spare
         logic unused_spare_bits;
         assign unused_spare_bits = ^wdata_i[UPD_POS-1:INC_HI+1];
      end
   endgenerate

   assign en_o     = en_q;
   assign pend_o   = pend_q;
   assign sh_inc_o = sh_inc_q;
   assign sh_thr_o = sh_thr_q;

   // R7: an applied request leaves nothing pending unless re-requested.
   a_r7_pend_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && apply_o && !upd_wr) |=> !pend_q);
   // R8: a stopped block never keeps a request beyond one clock.
   a_r8_idle_apply: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !en_q && !upd_wr) |=> !pend_q);
   // R3: writes elsewhere leave the register alone.
   a_r3_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && !sel) |=> ($stable(en_q) && $stable(sh_inc_q) && $stable(sh_thr_q)));
endmodule

// File: rtl/pwm_acc_phase.sv
module pwm_acc_phase #(
   parameter int ACC_W = 16,
   parameter int THR_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic [ACC_W-1:0] inc_i,
   output logic [THR_W-1:0] acc_hi_o,
   output logic             wrap_o
);
   logic [ACC_W-1:0] acc_q;
   logic [ACC_W:0]   sum;

   assign sum      = {1'b0, acc_q} + {1'b0, inc_i};
   assign wrap_o   = en_i & sum[ACC_W];
   assign acc_hi_o = acc_q[ACC_W-1 -: THR_W];

   always_ff @(posedge clk) begin
      if (!rst_n)    acc_q <= '0;
      else if (en_i) acc_q <= sum[ACC_W-1:0];
   end

   // R4: a stopped accumulator holds its phase.
   a_r4_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> $stable(acc_q));
   // R4: a running accumulator advances by the increment, modulo 2^ACC_W.
   a_r4_advance: assert property (@(posedge clk) disable iff (!rst_n)
      en_i |=> (ACC_W'(acc_q - $past(acc_q)) == $past(inc_i)));
endmodule

// File: rtl/pwm_acc_stage.sv
module pwm_acc_stage #(
   parameter int ACC_W = 16,
   parameter int THR_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             apply_i,
   input  logic             pend_i,
   input  logic [ACC_W-1:0] sh_inc_i,
   input  logic [THR_W-1:0] sh_thr_i,
   output logic [ACC_W-1:0] act_inc_o,
   output logic [THR_W-1:0] act_thr_o,
   output logic             act_zero_o
);
   logic [ACC_W-1:0] act_inc_q;
   logic [THR_W-1:0] act_thr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_inc_q <= '0;
         act_thr_q <= '0;
      end else if (apply_i) begin
         act_inc_q <= sh_inc_i;
         act_thr_q <= sh_thr_i;
      end
   end

   assign act_inc_o  = act_inc_q;
   assign act_thr_o  = act_thr_q;
   assign act_zero_o = (act_inc_q == '0);

   // R6: active settings move only on an apply edge.
   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !apply_i |=> ($stable(act_inc_q) && $stable(act_thr_q)));
   // R6: an apply only happens for a pending request.
   a_r6_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
      apply_i |-> pend_i);
endmodule

// File: rtl/pwm_acc_cmp.sv
module pwm_acc_cmp
   import pwm_acc_pkg::*;
#(
   parameter int        THR_W    = 8,
   parameter out_mode_e OUT_MODE = OUT_DIRECT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic [THR_W-1:0] acc_hi_i,
   input  logic [THR_W-1:0] thr_i,
   output logic             pwm_o
);
   logic hit;
   assign hit = en_i & (acc_hi_i < thr_i);

   generate
      if (OUT_MODE == OUT_RETIMED) begin : g_retimed
         logic pwm_q;
         always_ff @(posedge clk) begin
            if (!rst_n) pwm_q <= 1'b0;
            else        pwm_q <= hit;
         end
         assign pwm_o = pwm_q;
         // R11: one clock after a stopped cycle the output is low.
         a_r11_off_low: assert property (@(posedge clk) disable iff (!rst_n)
            !en_i |=> !pwm_o);
      end else begin : g_direct
         assign pwm_o = hit;
         // R5: a zero threshold never drives the output high.
         a_r5_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
            (thr_i == '0) |-> !pwm_o);
         // R4: a stopped block keeps the output low.
         a_r4_off_low: assert property (@(posedge clk) disable iff (!rst_n)
            !en_i |-> !pwm_o);
      end
   endgenerate
endmodule

// File: rtl/pwm_acc_gen.sv
module pwm_acc_gen
   import pwm_acc_pkg::*;
#(
   parameter int        ACC_W    = 16,
   parameter int        THR_W    = 8,
   parameter int        ADDR_W   = 4,
   parameter out_mode_e OUT_MODE = OUT_DIRECT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              pwm_o
);
   generate
      if (THR_W + ACC_W > UPD_POS) begin : g_bad_fields
         $error("pwm_acc_gen: increment and threshold fields overlap control bits");
      end
      if (THR_W > ACC_W) begin : g_bad_thr
         $error("pwm_acc_gen: threshold wider than accumulator");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("pwm_acc_gen: ADDR_W must be at least 1");
      end
   endgenerate

   logic             en, pend, apply, wrap, act_zero;
   logic [ACC_W-1:0] sh_inc, act_inc;
   logic [THR_W-1:0] sh_thr, act_thr, acc_hi;

   pwm_acc_regs #(.ACC_W(ACC_W), .THR_W(THR_W), .ADDR_W(ADDR_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .we_i       (reg_we),
      .addr_i     (reg_addr),
      .wdata_i    (reg_wdata),
      .rdata_o    (reg_rdata),
      .wrap_i     (wrap),
      .act_zero_i (act_zero),
      .en_o       (en),
      .pend_o     (pend),
      .sh_inc_o   (sh_inc),
      .sh_thr_o   (sh_thr),
      .apply_o    (apply)
   );

   pwm_acc_stage #(.ACC_W(ACC_W), .THR_W(THR_W)) u_stage (
      .clk        (clk),
      .rst_n      (rst_n),
      .apply_i    (apply),
      .pend_i     (pend),
      .sh_inc_i   (sh_inc),
      .sh_thr_i   (sh_thr),
      .act_inc_o  (act_inc),
      .act_thr_o  (act_thr),
      .act_zero_o (act_zero)
   );

   pwm_acc_phase #(.ACC_W(ACC_W), .THR_W(THR_W)) u_phase (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_i     (en),
      .inc_i    (act_inc),
      .acc_hi_o (acc_hi),
      .wrap_o   (wrap)
   );

   pwm_acc_cmp #(.THR_W(THR_W), .OUT_MODE(OUT_MODE)) u_cmp (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_i     (en),
      .acc_hi_i (acc_hi),
      .thr_i    (act_thr),
      .pwm_o    (pwm_o)
   );
endmodule

// File: tb/pwm_acc_gen_test.sv
`timescale 1ns/1ps
module pwm_acc_gen_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        we = 1'b0;
   logic [3:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rd_a, rd_b;
   logic        pwm_a, pwm_b;

   int n_chk = 0;
   int n_fail = 0;
   int hc;

   always #10 clk = ~clk;

   pwm_acc_gen uut (
      .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_addr(addr),
      .reg_wdata(wdata), .reg_rdata(rd_a), .pwm_o(pwm_a));

   pwm_acc_gen #(.OUT_MODE(pwm_acc_pkg::OUT_RETIMED)) uut_reg (
      .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_addr(addr),
      .reg_wdata(wdata), .reg_rdata(rd_b), .pwm_o(pwm_b));

   // Behavioural reference model
   logic        m_en = 0, m_pend = 0, m_oq = 0;
   logic [15:0] m_acc = 0, m_shi = 0, m_ai = 0;
   logic [7:0]  m_sht = 0, m_at = 0;

   function automatic logic m_out();
      return m_en && (m_acc[15:8] < m_at);
   endfunction

   function automatic logic [31:0] m_rd(input logic [3:0] a);
      if (a != 0) return 32'h0;
      return {m_en, m_pend, 6'h00, m_shi, m_sht};
   endfunction

   always @(posedge clk) begin
      logic [16:0] s;
      logic carry, ap, pn;
      if (!rst_n) begin
         m_en = 0; m_pend = 0; m_oq = 0; m_acc = 0;
         m_shi = 0; m_sht = 0; m_ai = 0; m_at = 0;
      end else begin
         s     = {1'b0, m_acc} + {1'b0, m_ai};
         carry = m_en && s[16];
         ap    = m_pend && (!m_en || carry || m_ai == 0);
         m_oq  = m_out();
         if (m_en) m_acc = s[15:0];
         if (ap) begin m_ai = m_shi; m_at = m_sht; end
         pn = ap ? 1'b0 : m_pend;
         if (we && addr == 0) begin
            m_en  = wdata[31];
            m_shi = wdata[23:8];
            m_sht = wdata[7:0];
            if (wdata[30]) pn = 1'b1;
         end
         m_pend = pn;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // One clock: compare at the falling edge, then drive the next inputs.
   task automatic step(input logic w, input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      if (rst_n) begin
         chk("R5 direct output vs model", {31'h0, pwm_a}, {31'h0, m_out()});
         chk("R11 retimed output vs model", {31'h0, pwm_b}, {31'h0, m_oq});
         chk("R2 readback vs model", rd_a, m_rd(addr));
      end
      we = w; addr = a; wdata = d;
      #1;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1'b0, 4'h0, 32'h0);
   endtask

   task automatic count_high(input int n, output int h);
      h = 0;
      for (int i = 0; i < n; i++) begin
         step(1'b0, 4'h0, 32'h0);
         h += int'(pwm_a);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; we = 1'b0; addr = '0; wdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
   endtask

   initial begin
      #(200000 * 20);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 reset readback", rd_a, 32'h0);
      chk("R1 reset output", {31'h0, pwm_a}, 32'h0);
      chk("R11 retimed reset output", {31'h0, pwm_b}, 32'h0);
      rst_n = 1'b1;

      // R3: stray address
      step(1'b1, 4'h3, 32'hFFFF_FFFF);
      step(1'b0, 4'h0, 32'h0);
      chk("R3 write to addr 3 ignored", rd_a, 32'h0);
      step(1'b0, 4'h3, 32'h0);
      chk("R3 read of addr 3", rd_a, 32'h0);

      // R2/R7/R8: configure while stopped
      step(1'b1, 4'h0, 32'h7F10_0040);
      step(1'b0, 4'h0, 32'h0);
      chk("R2 field readback, bits 29:24 zero", rd_a, 32'h4010_0040);
      step(1'b0, 4'h0, 32'h0);
      chk("R8 applied while stopped", rd_a, 32'h0010_0040);

      // R5: 25% duty
      step(1'b1, 4'h0, 32'h8010_0040);
      count_high(16, hc);
      chk("R5 duty 0x40 highs per period", hc, 4);

      // R6/R7: staged update
      step(1'b1, 4'h0, 32'hC010_00C0);
      step(1'b0, 4'h0, 32'h0);
      chk("R7 pending reads 1", rd_a, 32'hC010_00C0);
      idle(20);
      chk("R6 applied at boundary", rd_a, 32'h8010_00C0);
      count_high(16, hc);
      chk("R6 new duty 0xC0", hc, 12);

      // R7: write without update does not reach active copy
      step(1'b1, 4'h0, 32'h8010_00FF);
      count_high(32, hc);
      chk("R7 no-update write ignored by output", hc, 24);
      chk("R7 shadow readback", rd_a, 32'h8010_00FF);

      // R5: zero threshold
      step(1'b1, 4'h0, 32'hC010_0000);
      idle(20);
      count_high(32, hc);
      chk("R5 zero threshold stays low", hc, 0);

      // R4: stopped
      step(1'b1, 4'h0, 32'hC010_0080);
      step(1'b1, 4'h0, 32'h0010_0080);
      count_high(20, hc);
      chk("R4 stopped output low", hc, 0);
      step(1'b1, 4'h0, 32'h8010_0080);
      idle(24);

      // R10: large increment
      step(1'b1, 4'h0, 32'hC0C0_0080);
      idle(20);
      count_high(4, hc);
      chk("R10 increment 0xC000 highs per 4", hc, 2);
      chk("R10 update applied", rd_a, 32'h80C0_0080);

      // R9/R11: write landing on a carry edge
      do_reset();
      step(1'b1, 4'h0, 32'h4080_0080);
      step(1'b0, 4'h0, 32'h0);
      step(1'b1, 4'h0, 32'h8080_0080);
      step(1'b0, 4'h0, 32'h0);
      step(1'b1, 4'h0, 32'hC080_0000);
      step(1'b0, 4'h0, 32'h0);
      chk("R9 request on carry edge still pending", rd_a, 32'hC080_0000);
      chk("R9 old threshold kept", {31'h0, pwm_a}, 32'h1);
      step(1'b0, 4'h0, 32'h0);
      chk("R11 retimed lags direct", {30'h0, pwm_b, pwm_a}, 32'h2);
      step(1'b0, 4'h0, 32'h0);
      chk("R9 applied at next carry", rd_a, 32'h8080_0000);
      chk("R9 new threshold zero", {31'h0, pwm_a}, 32'h0);
      idle(8);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule